// File: doc/BRIEF.md
# Host Bridge Control Register Interface

This block is the register front end of a host bridge that connects a processor complex to a service processor. It answers 64-bit register requests on a simple request/response bus inside a 1 MiB window. The window is placed by a base register that can only be written through a second, write-only configuration port. The register file holds a control word and a semaphore word, both of which ignore writes. It also holds an interrupt-control word, an event-page base, a notification address and a vector offset.

The interrupt-control word selects the interrupt method. Writing it with the reset bit set sends a one-cycle reset pulse to the interrupt source. The event-page base carries a valid flag in its least significant bit. A rising flag maps a separate event window at the written address with the flag bit cleared, and a falling flag unmaps it. The notification unit reads the stored notification address and vector offset directly from output ports.

Data words use big-endian bit numbering, in which "bit k (MSB-0)" is bit 63-k of the vectors. Every response appears on the clock edge that follows the request.

Top module: `hbctl_regs`

## Requirements
- R1: After a synchronous active-low reset, all registers read as zero and `bar_base`, `bar_en`, `win_en`, `win_base`, `notify_addr`, `vec_offset`, `irq_method` and `src_reset` are all 0.
- R2: A configuration write with `cfg_size`=8 to configuration byte offset 0x00 loads `bar_base` with the write data ANDed with 0x00ff_ffff_fff0_0000, and loads `bar_en` with data bit 0 (LSB). The response has `cfg_rsp_err`=0.
- R3: A configuration read returns all ones with `cfg_rsp_err`=1. A configuration write to any other offset, or with a size other than 8, returns `cfg_rsp_err`=1 and leaves `bar_base` and `bar_en` unchanged.
- R4: A main request hits only when `bar_en`=1 and `req_addr[63:20]` equals `bar_base[63:20]`. A miss returns `rsp_err`=1 (read data all ones) and changes no register.
- R5: Each main request produces exactly one response with `rsp_valid`=1 on the next clock edge. A read of an implemented offset returns the stored value with `rsp_err`=0.
- R6: A main request at an offset other than 0x20, 0x28, 0x58, 0x60, 0x68 or 0x70, a request not aligned to 8 bytes, or a request with `req_size` other than 8 returns `rsp_err`=1. For a read the data is all ones. For a write nothing is stored.
- R7: Writes to the control word (0x20) and the semaphore word (0x28) are accepted with `rsp_err`=0 and discarded, so both offsets keep reading zero.
- R8: A write to interrupt control (0x58) stores all 64 bits, and `irq_method` follows stored bit 0 (MSB-0, vector bit 63).
- R9: A write to 0x58 with bit 1 (MSB-0, vector bit 62) set raises `src_reset` for exactly one cycle, aligned with the response. A write with that bit clear does not raise it.
- R10: A write to the event-page base (0x60) whose bit 0 (LSB) is 1 while the stored flag is 0 sets `win_en`=1 and sets `win_base` to the written value with bit 0 cleared.
- R11: A write to 0x60 with bit 0 cleared while the flag is set drops `win_en`. A write that leaves the flag unchanged keeps `win_en` and `win_base` as they were, although the full value is stored and read back.
- R12: Writes to 0x68 and 0x70 are stored in full, read back, and appear on `notify_addr` and `vec_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Main request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 64 | Main request byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Main write data |
| rsp_valid | output | 1 | Main response strobe |
| rsp_rdata | output | 64 | Main read data |
| rsp_err | output | 1 | Main response error |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_write | input | 1 | 1 for write, 0 for read |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_size | input | 4 | Configuration access size in bytes |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rsp_valid | output | 1 | Configuration response strobe |
| cfg_rsp_rdata | output | 64 | Configuration read data (all ones on reads) |
| cfg_rsp_err | output | 1 | Configuration response error |
| bar_base | output | 64 | Masked main window base |
| bar_en | output | 1 | Main window enable |
| irq_method | output | 1 | Interrupt method select |
| src_reset | output | 1 | One-cycle reset pulse to the interrupt source |
| win_en | output | 1 | Event window mapped |
| win_base | output | 64 | Event window base address |
| notify_addr | output | 64 | Stored notification address |
| vec_offset | output | 64 | Stored vector offset |

## Verification
The bench reads every 8-byte word of the first 256 bytes of the window. The expected value and error flag for each word come from the offset list, which separates implemented offsets from unimplemented ones. Complementary bit patterns and walking ones are written to the data registers to show that every bit is stored and read back. The same patterns on the interrupt-control word separate the method bit from the reset-pulse bit. The event-page base is stepped through rise, same-flag rewrite, fall and a second rise, which separates a mapping that tracks transitions from one that tracks every write. Window misses, wrong sizes, misalignment and moving or disabling the base register are each shown to leave all stored state unchanged.

// File: rtl/hbctl_pkg.sv
// Package: shared constants and types for the host bridge control registers.
// Assumes 64-bit data words with MSB-0 naming (bit k MSB-0 = vector bit 63-k).
package hbctl_pkg;
    localparam int unsigned DATA_W = 64;

    // Word indices in the main window (byte offset >> 3)
    localparam int unsigned IDX_CTRL = 'h20 >> 3;
    localparam int unsigned IDX_SEMA = 'h28 >> 3;
    localparam int unsigned IDX_ICTL = 'h58 >> 3;
    localparam int unsigned IDX_EVB  = 'h60 >> 3;
    localparam int unsigned IDX_NTFY = 'h68 >> 3;
    localparam int unsigned IDX_VOFF = 'h70 >> 3;

    // Bit positions (LSB-0 vector indices)
    localparam int unsigned ICTL_METHOD_BIT = 63;  // MSB-0 bit 0
    localparam int unsigned ICTL_RESET_BIT  = 62;  // MSB-0 bit 1
    localparam int unsigned EVB_VALID_BIT   = 0;
    localparam int unsigned BAR_EN_BIT      = 0;

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_SEMA, SEL_ICTL, SEL_EVB, SEL_NTFY, SEL_VOFF
    } reg_sel_e;
endpackage

// File: rtl/hbctl_bar.sv
// Module: configuration port that holds the main window base register.
// Only an 8-byte write to offset 0 is accepted; reads always return all
// ones with an error. The response is registered one cycle after the request.
module hbctl_bar #(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned CFG_AW   = 8,
    parameter int unsigned SIZE_W   = 4,
    parameter logic [63:0] BAR_MASK = 64'h00ff_ffff_fff0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_rsp_valid,
    output logic [63:0]       cfg_rsp_rdata,
    output logic              cfg_rsp_err,
    output logic [ADDR_W-1:0] bar_base,
    output logic              bar_en
);
    import hbctl_pkg::*;

    localparam logic [SIZE_W-1:0] WORD_BYTES = SIZE_W'(8);

    logic bar_wr_ok;

    // Accept only a full-word write to the single base register
    always_comb bar_wr_ok = cfg_valid && cfg_write && (cfg_addr == '0)
                            && (cfg_size == WORD_BYTES);

    // Base register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_base <= '0;
            bar_en   <= 1'b0;
        end else if (bar_wr_ok) begin
            bar_base <= ADDR_W'(cfg_wdata & BAR_MASK);
            bar_en   <= cfg_wdata[BAR_EN_BIT];
        end
    end

    // Configuration response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rsp_valid <= 1'b0;
            cfg_rsp_rdata <= '0;
            cfg_rsp_err   <= 1'b0;
        end else begin
            cfg_rsp_valid <= cfg_valid;
            cfg_rsp_rdata <= (cfg_valid && !cfg_write) ? ALL_ONES : '0;
            cfg_rsp_err   <= cfg_valid && !bar_wr_ok;
        end
    end

    p_cfg_read_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write) |=> (cfg_rsp_valid && cfg_rsp_err && (cfg_rsp_rdata == ALL_ONES)));

    p_cfg_bad_write_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && (cfg_addr != '0)) |=> ($stable(bar_base) && $stable(bar_en) && cfg_rsp_err));

    p_bar_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && (cfg_addr == '0) && (cfg_size == WORD_BYTES))
        |=> ((bar_base == ADDR_W'($past(cfg_wdata) & BAR_MASK)) && !cfg_rsp_err));
endmodule

// File: rtl/hbctl_decode.sv
// Module: combinational window match and register select for the main bus.
// Assumes the window is 2**WIN_SHIFT bytes, aligned to its size.
module hbctl_decode #(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned WIN_SHIFT = 20,
    parameter int unsigned SIZE_W    = 4
) (
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [SIZE_W-1:0]           req_size,
    input  logic [ADDR_W-WIN_SHIFT-1:0] bar_hi,
    input  logic                        bar_en,
    output logic                        hit,
    output hbctl_pkg::reg_sel_e         sel
);
    import hbctl_pkg::*;

    localparam int unsigned IDX_W = WIN_SHIFT - 3;
    localparam logic [SIZE_W-1:0] WORD_BYTES = SIZE_W'(8);

    logic [IDX_W-1:0] idx;

    // Base-plus-mask window match
    always_comb hit = bar_en && (req_addr[ADDR_W-1:WIN_SHIFT] == bar_hi);

    // Word index select among the implemented registers
    always_comb begin
        idx = req_addr[WIN_SHIFT-1:3];
        sel = SEL_NONE;
        if (hit && (req_size == WORD_BYTES) && (req_addr[2:0] == 3'b000)) begin
            if      (idx == IDX_W'(IDX_CTRL)) sel = SEL_CTRL;
            else if (idx == IDX_W'(IDX_SEMA)) sel = SEL_SEMA;
            else if (idx == IDX_W'(IDX_ICTL)) sel = SEL_ICTL;
            else if (idx == IDX_W'(IDX_EVB))  sel = SEL_EVB;
            else if (idx == IDX_W'(IDX_NTFY)) sel = SEL_NTFY;
            else if (idx == IDX_W'(IDX_VOFF)) sel = SEL_VOFF;
        end
    end
endmodule

// File: rtl/hbctl_regfile.sv
// Module: main register file, event window tracking and source reset pulse.
// Assumes sel is already qualified by window hit, size and alignment.
module hbctl_regfile (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  hbctl_pkg::reg_sel_e sel,
    input  logic [63:0]         req_wdata,
    output logic                rsp_valid,
    output logic [63:0]         rsp_rdata,
    output logic                rsp_err,
    output logic                irq_method,
    output logic                src_reset,
    output logic                win_en,
    output logic [63:0]         win_base,
    output logic [63:0]         notify_addr,
    output logic [63:0]         vec_offset
);
    import hbctl_pkg::*;

    logic [63:0] ctrl_q, sema_q, ictl_q, evb_q;
    logic [63:0] rd_mux;
    logic        wr_en;

    always_comb wr_en = req_valid && req_write;

    // Read data select
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_SEMA: rd_mux = sema_q;
            SEL_ICTL: rd_mux = ictl_q;
            SEL_EVB:  rd_mux = evb_q;
            SEL_NTFY: rd_mux = notify_addr;
            SEL_VOFF: rd_mux = vec_offset;
            default:  rd_mux = ALL_ONES;
        endcase
    end

    // Control and semaphore words: writes are discarded, value held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sema_q <= '0;
        end
    end

    // Storage of the writable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ictl_q      <= '0;
            evb_q       <= '0;
            notify_addr <= '0;
            vec_offset  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ICTL: ictl_q      <= req_wdata;
                SEL_EVB:  evb_q       <= req_wdata;
                SEL_NTFY: notify_addr <= req_wdata;
                SEL_VOFF: vec_offset  <= req_wdata;
                default: ;
            endcase
        end
    end

    // Event window base captured only on a rising valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base <= '0;
        end else if (wr_en && (sel == SEL_EVB) && req_wdata[EVB_VALID_BIT]
                     && !evb_q[EVB_VALID_BIT]) begin
            win_base <= req_wdata & ~64'h1;
        end
    end

    // Response and source reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            src_reset <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
            rsp_err   <= req_valid && (sel == SEL_NONE);
            src_reset <= wr_en && (sel == SEL_ICTL) && req_wdata[ICTL_RESET_BIT];
        end
    end

    always_comb begin
        win_en     = evb_q[EVB_VALID_BIT];
        irq_method = ictl_q[ICTL_METHOD_BIT];
    end

    p_win_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_EVB) && req_wdata[0] && !win_en)
        |=> (win_en && (win_base == ($past(req_wdata) & ~64'h1))));

    p_win_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && $past(win_en)) |-> $stable(win_base));

    p_src_reset_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_reset |-> ($past(wr_en) && ($past(sel) == SEL_ICTL)));

    p_ctrl_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (sel == SEL_CTRL || sel == SEL_SEMA)) |=> (rsp_rdata == '0));
endmodule

// File: rtl/hbctl_regs.sv
// Module: top of the host bridge control register interface.
// Joins the configuration port, window decode and register file.
// Assumes one outstanding request per port; responses follow in one cycle.
module hbctl_regs #(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned WIN_SHIFT = 20,
    parameter int unsigned SIZE_W    = 4,
    parameter int unsigned CFG_AW    = 8,
    parameter logic [63:0] BAR_MASK  = 64'h00ff_ffff_fff0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_rsp_valid,
    output logic [63:0]       cfg_rsp_rdata,
    output logic              cfg_rsp_err,
    output logic [ADDR_W-1:0] bar_base,
    output logic              bar_en,
    output logic              irq_method,
    output logic              src_reset,
    output logic              win_en,
    output logic [63:0]       win_base,
    output logic [63:0]       notify_addr,
    output logic [63:0]       vec_offset
);
    import hbctl_pkg::*;

    localparam int unsigned HI_W = ADDR_W - WIN_SHIFT;

    logic     hit;
    reg_sel_e sel;

    hbctl_bar #(
        .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .SIZE_W(SIZE_W), .BAR_MASK(BAR_MASK)
    ) u_bar (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
        .cfg_rsp_err(cfg_rsp_err), .bar_base(bar_base), .bar_en(bar_en)
    );

    hbctl_decode #(
        .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .SIZE_W(SIZE_W)
    ) u_dec (
        .req_addr(req_addr), .req_size(req_size),
        .bar_hi(bar_base[ADDR_W-1:WIN_SHIFT]), .bar_en(bar_en),
        .hit(hit), .sel(sel)
    );

    hbctl_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .sel(sel),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .irq_method(irq_method), .src_reset(src_reset),
        .win_en(win_en), .win_base(win_base),
        .notify_addr(notify_addr), .vec_offset(vec_offset)
    );

    p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_miss_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_err && $stable(notify_addr) && $stable(vec_offset)));

    p_hit_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit) |-> (req_addr[ADDR_W-1:WIN_SHIFT] == bar_base[ADDR_W-1:WIN_SHIFT]) && (HI_W > 0));
endmodule

// File: tb/sim_hbctl_regs.sv
// Bench: directed sweeps over the register window and configuration port.
module sim_hbctl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [63:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_size = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        cfg_valid = 0, cfg_write = 0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_size = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_rsp_valid, cfg_rsp_err;
    logic [63:0] cfg_rsp_rdata;
    logic [63:0] bar_base, win_base, notify_addr, vec_offset;
    logic        bar_en, irq_method, src_reset, win_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [63:0] r_data;
    logic        r_err, r_valid, r_srst;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbctl_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
        .cfg_rsp_err(cfg_rsp_err),
        .bar_base(bar_base), .bar_en(bar_en), .irq_method(irq_method),
        .src_reset(src_reset), .win_en(win_en), .win_base(win_base),
        .notify_addr(notify_addr), .vec_offset(vec_offset)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One main-bus access; response sampled at the following falling edge
    task automatic bus(input logic w, input logic [63:0] a, input logic [3:0] s,
                       input logic [63:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        r_valid = rsp_valid; r_data = rsp_rdata; r_err = rsp_err; r_srst = src_reset;
        req_valid = 0; req_write = 0;
    endtask

    // One configuration-port access
    task automatic cfg(input logic w, input logic [7:0] a, input logic [3:0] s,
                       input logic [63:0] d);
        cfg_valid = 1; cfg_write = w; cfg_addr = a; cfg_size = s; cfg_wdata = d;
        @(negedge clk);
        r_valid = cfg_rsp_valid; r_data = cfg_rsp_rdata; r_err = cfg_rsp_err;
        cfg_valid = 0; cfg_write = 0;
    endtask

    function automatic bit is_impl(input logic [63:0] off);
        return off == 'h20 || off == 'h28 || off == 'h58 || off == 'h60 ||
               off == 'h68 || off == 'h70;
    endfunction

    localparam logic [63:0] BASE  = 64'h0006_0302_0300_0000;
    localparam logic [63:0] ONES  = '1;
    localparam logic [63:0] PAT_A = 64'h0123_4567_89ab_cdef;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bar_en", {63'b0, bar_en}, 64'h0);
        chk("R1 bar_base", bar_base, 64'h0);
        chk("R1 win_en", {63'b0, win_en}, 64'h0);
        chk("R1 win_base", win_base, 64'h0);
        chk("R1 notify", notify_addr, 64'h0);
        chk("R1 vecoff", vec_offset, 64'h0);
        chk("R1 method", {62'b0, irq_method, src_reset}, 64'h0);

        // R4 window disabled: every access misses
        bus(0, 64'h20, 8, 0);
        chk("R4 miss disabled err", {63'b0, r_err}, 64'h1);
        chk("R4 miss disabled data", r_data, ONES);

        // R3 configuration port rejections
        cfg(0, 8'h00, 8, 0);
        chk("R3 cfg read err", {63'b0, r_err}, 64'h1);
        chk("R3 cfg read data", r_data, ONES);
        cfg(1, 8'h08, 8, BASE | 1);
        chk("R3 cfg bad offset err", {63'b0, r_err}, 64'h1);
        chk("R3 cfg bad offset bar", {63'b0, bar_en}, 64'h0);
        cfg(1, 8'h00, 4, BASE | 1);
        chk("R3 cfg bad size err", {63'b0, r_err}, 64'h1);
        chk("R3 cfg bad size bar", bar_base, 64'h0);

        // R2 base register masking and enable
        cfg(1, 8'h00, 8, ONES);
        chk("R2 mask all ones", bar_base, ONES & 64'h00ff_ffff_fff0_0000);
        chk("R2 enable", {63'b0, bar_en}, 64'h1);
        cfg(1, 8'h00, 8, BASE | 64'h1 | 64'h000f_ffff & ~64'h1);
        chk("R2 base", bar_base, BASE);
        chk("R2 err", {63'b0, r_err}, 64'h0);

        // R5 R6 sweep the first 32 words of the window
        for (int i = 0; i < 32; i++) begin
            logic [63:0] off;
            off = 64'(i) << 3;
            bus(0, BASE + off, 8, 0);
            chk($sformatf("R5 valid @%h", off), {63'b0, r_valid}, 64'h1);
            if (is_impl(off)) begin
                chk($sformatf("R5 data @%h", off), r_data, 64'h0);
                chk($sformatf("R5 err @%h", off), {63'b0, r_err}, 64'h0);
            end else begin
                chk($sformatf("R6 data @%h", off), r_data, ONES);
                chk($sformatf("R6 err @%h", off), {63'b0, r_err}, 64'h1);
            end
        end
        bus(0, BASE + 64'hf_fff8, 8, 0);
        chk("R6 top word", r_data, ONES);

        // R12 data registers with complementary and walking patterns
        for (int k = 0; k < 6; k++) begin
            logic [63:0] p, q;
            p = (k == 0) ? PAT_A : (k == 1) ? ~PAT_A : (64'h1 << (k * 13));
            q = ~p ^ (64'h1 << k);
            bus(1, BASE + 'h68, 8, p);
            bus(1, BASE + 'h70, 8, q);
            chk("R12 notify out", notify_addr, p);
            chk("R12 vecoff out", vec_offset, q);
            bus(0, BASE + 'h68, 8, 0);
            chk("R12 notify read", r_data, p);
            bus(0, BASE + 'h70, 8, 0);
            chk("R12 vecoff read", r_data, q);
        end

        // R6 rejected writes leave the register unchanged
        bus(1, BASE + 'h68, 8, 64'hAAAA);
        bus(1, BASE + 'h68, 4, 64'h5555);
        chk("R6 size err", {63'b0, r_err}, 64'h1);
        bus(1, BASE + 'h6c, 8, 64'h5555);
        chk("R6 misalign err", {63'b0, r_err}, 64'h1);
        chk("R6 unchanged", notify_addr, 64'hAAAA);
        bus(1, BASE + 'h78, 8, 64'h5555);
        chk("R6 unimpl write err", {63'b0, r_err}, 64'h1);

        // R4 address outside the window
        bus(1, BASE + 64'h10_0068, 8, 64'h7777);
        chk("R4 outside err", {63'b0, r_err}, 64'h1);
        chk("R4 outside unchanged", notify_addr, 64'hAAAA);

        // R7 control and semaphore discard writes
        bus(1, BASE + 'h20, 8, ONES);
        chk("R7 ctrl write err", {63'b0, r_err}, 64'h0);
        bus(1, BASE + 'h28, 8, PAT_A);
        bus(0, BASE + 'h20, 8, 0);
        chk("R7 ctrl read", r_data, 64'h0);
        bus(0, BASE + 'h28, 8, 0);
        chk("R7 sema read", r_data, 64'h0);

        // R8 R9 interrupt control
        bus(1, BASE + 'h58, 8, 64'hC000_0000_0000_1234);
        chk("R9 pulse on write", {63'b0, r_srst}, 64'h1);
        chk("R8 method set", {63'b0, irq_method}, 64'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {63'b0, src_reset}, 64'h0);
        bus(0, BASE + 'h58, 8, 0);
        chk("R8 stored full", r_data, 64'hC000_0000_0000_1234);
        bus(1, BASE + 'h58, 8, 64'h8000_0000_0000_0000);
        chk("R9 no pulse", {63'b0, r_srst}, 64'h0);
        bus(1, BASE + 'h58, 8, 64'h4000_0000_0000_0000);
        chk("R9 pulse method clear", {63'b0, r_srst}, 64'h1);
        chk("R8 method clear", {63'b0, irq_method}, 64'h0);

        // R10 R11 event window transitions
        bus(1, BASE + 'h60, 8, 64'h0000_0012_3450_0001);
        chk("R10 win_en rise", {63'b0, win_en}, 64'h1);
        chk("R10 win_base", win_base, 64'h0000_0012_3450_0000);
        bus(1, BASE + 'h60, 8, 64'h0000_0099_9900_0001);
        chk("R11 base kept", win_base, 64'h0000_0012_3450_0000);
        chk("R11 still enabled", {63'b0, win_en}, 64'h1);
        bus(0, BASE + 'h60, 8, 0);
        chk("R11 stored value", r_data, 64'h0000_0099_9900_0001);
        bus(1, BASE + 'h60, 8, 64'h0000_0099_9900_0000);
        chk("R11 fall", {63'b0, win_en}, 64'h0);
        bus(1, BASE + 'h60, 8, 64'h0000_0000_0000_0000);
        chk("R11 stays off", {63'b0, win_en}, 64'h0);
        bus(1, BASE + 'h60, 8, 64'h0000_0000_00ab_c001);
        chk("R10 second rise", win_base, 64'h0000_0000_00ab_c000);

        // R4 moved and disabled base
        cfg(1, 8'h00, 8, 64'h0000_0000_0050_0001);
        bus(0, 64'h0000_0000_0050_0068, 8, 0);
        chk("R4 moved hit", r_data, 64'hAAAA);
        cfg(1, 8'h00, 8, 64'h0000_0000_0050_0000);
        bus(0, 64'h0000_0000_0050_0068, 8, 0);
        chk("R4 disabled miss", {63'b0, r_err}, 64'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule